// File: doc/BRIEF.md
# Linked-List Command Block Walker

The walker follows a chain of command blocks stored in main memory and passes the payload of each block to a command consumer. A block starts with one header word. The header gives the number of payload words that follow it and the address of the next block. After a start pulse the walker fetches the header at the start address. It then fetches and forwards that block's payload words one at a time, and moves on to the next block. It stops when a next-block address carries the end marker.

A corrupt or self-referencing chain must not hang the engine. To guard against this, the walker keeps a checkpoint address and a node interval that doubles each time it is used up. If a next-block address equals the checkpoint, the walk ends as a loop abort. While walking, the block adds up an estimated processing cost for the chain. At the end it reports a one-cycle done pulse, a loop flag and the final cost. Memory is reached through a request port and a response port, with one read outstanding at a time. The consumer is reached through a valid/ready stream.

Top module: `lldma_walker`

## Requirements
- R1: After reset the walker is idle: busy, done, loop flag, memory request valid and command valid are all 0, and the cost output is 0.
- R2: A header word carries the payload word count in bits 31:24 and the next-block address in bits 23:0. Every memory request uses the byte address formed from address bits 20:0 with bits 1:0 cleared, so bits 23:21 select nothing in memory. The header is read at the block address, and payload word k (k from 0) is read at that address plus 4*(k+1).
- R3: Each block's payload words are sent on the command port in increasing address order, exactly as many as the header count. A block with count 0 sends nothing. No memory request is raised while a command word is on offer.
- R4: A command word that is offered but not accepted stays offered, with the same data, until the consumer takes it. No word is dropped or repeated.
- R5: The walk ends normally after a block whose next address has bit 23 set. A start address with bit 23 set ends the walk without any memory request: done rises in the cycle after the start edge, and the cost is 0.
- R6: The cost starts at 0 on each start. Each block fetched adds 10, and a block with a nonzero count adds a further 5 plus its count.
- R7: On start, the checkpoint takes the start address, the interval is 32 and the block count is 0. After each block the next address is first compared with the checkpoint, and a match ends the walk with the loop flag set. If there is no match and the walk is not ending, then when the block count equals the interval, the checkpoint takes the next address and the interval doubles. The block count then goes up by one.
- R8: The end of a walk gives done high for exactly one cycle with busy low. The loop flag is 1 only for a loop abort. The loop flag and the cost hold their values until the next accepted start.
- R9: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (sampled while idle) |
| start_addr_i | input | 24 | Address of the first block |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 21 | Word-aligned byte address of the read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| cmd_valid_o | output | 1 | Payload word on offer |
| cmd_ready_i | input | 1 | Consumer takes the word |
| cmd_data_o | output | 32 | Payload word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when a walk ends |
| loop_abort_o | output | 1 | Last walk ended on a detected loop |
| cost_o | output | 32 | Accumulated cost of the last walk |

## Verification
Only the end marker on the start address has a fixed latency: done must be high in the first cycle after the start edge. The bench samples that exact cycle, away from the edge, and checks that done is low again one cycle later. A normal walk ends one cycle after its last payload handshake, or one cycle after its last header response if that block is empty. Because memory latency and consumer stalls make this point vary, the bench waits for the done pulse and only then compares the captured stream, the cost and the loop flag against a model walk of its own memory image. It then checks one cycle later that done has dropped and that the cost and loop flag are held. Payload words are captured from the handshake values in the half cycle before each edge, so stall cycles never add or drop a word.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_PAY_REQ,
        ST_PAY_WAIT,
        ST_PAY_SEND,
        ST_LINK
    } walk_st_e;

endpackage

// File: rtl/lldma_loop_guard.sv
// Checkpoint-based cycle detector with a doubling node interval.
module lldma_loop_guard #(
    parameter int ADDR_W         = 24,
    parameter int CNT_W          = 32,
    parameter int FIRST_INTERVAL = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [ADDR_W-1:0] init_addr_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] next_addr_i,
    output logic              hit_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] ckpt;
        logic [CNT_W-1:0]  interval;
        logic [CNT_W-1:0]  count;
    } guard_t;

    guard_t g_d, g_q;

    assign hit_o = (next_addr_i == g_q.ckpt);

    always_comb begin
        g_d = g_q;
        if (init_i) begin
            g_d.ckpt     = init_addr_i;
            g_d.interval = CNT_W'(FIRST_INTERVAL);
            g_d.count    = '0;
        end else if (step_i) begin
            if (g_q.count == g_q.interval) begin
                g_d.ckpt = next_addr_i;
                // saturate instead of wrapping to zero
                if (!g_q.interval[CNT_W-1]) begin
                    g_d.interval = g_q.interval << 1;
                end
            end
            g_d.count = g_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

endmodule

// File: rtl/lldma_cost_acc.sv
// Per-walk cost estimate: fixed charge per block plus a payload-dependent charge.
module lldma_cost_acc #(
    parameter int COST_W     = 32,
    parameter int LEN_W      = 8,
    parameter int NODE_COST  = 10,
    parameter int BLOCK_COST = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              add_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [COST_W-1:0] cost_o
);

    logic [COST_W-1:0] cost_d, cost_q;
    logic [COST_W-1:0] extra;

    always_comb begin
        extra  = (len_i != '0) ? (COST_W'(BLOCK_COST) + COST_W'(len_i)) : '0;
        cost_d = cost_q;
        if (init_i) begin
            cost_d = '0;
        end else if (add_i) begin
            cost_d = cost_q + COST_W'(NODE_COST) + extra;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cost_q <= '0;
        end else begin
            cost_q <= cost_d;
        end
    end

    assign cost_o = cost_q;

endmodule

// File: rtl/lldma_walker.sv
// Walks a chain of command blocks in memory and streams their payload words.
module lldma_walker
    import lldma_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int MEM_AW         = 21,
    parameter int DATA_W         = 32,
    parameter int LEN_W          = 8,
    parameter int COST_W         = 32,
    parameter int CNT_W          = 32,
    parameter int FIRST_INTERVAL = 32,
    parameter int NODE_COST      = 10,
    parameter int BLOCK_COST     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [MEM_AW-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [DATA_W-1:0] cmd_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              loop_abort_o,
    output logic [COST_W-1:0] cost_o
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORD_LSB   = $clog2(WORD_BYTES);
    localparam int END_BIT    = ADDR_W - 1;

    typedef struct packed {
        walk_st_e          st;
        logic [MEM_AW-1:0] rd_addr;
        logic [ADDR_W-1:0] next_addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
        logic [DATA_W-1:0] word;
        logic              done;
        logic              loop_abort;
    } walk_t;

    walk_t w_d, w_q;

    logic             guard_init, guard_step, loop_hit;
    logic             cost_init, cost_add;
    logic [LEN_W-1:0] hdr_len;
    logic [ADDR_W-1:0] hdr_next;

    function automatic logic [MEM_AW-1:0] word_addr(input logic [ADDR_W-1:0] a);
        logic [MEM_AW-1:0] m;
        m = a[MEM_AW-1:0];
        m[WORD_LSB-1:0] = '0;
        return m;
    endfunction

    assign hdr_len  = mem_rsp_data_i[DATA_W-1 -: LEN_W];
    assign hdr_next = mem_rsp_data_i[ADDR_W-1:0];

    always_comb begin
        w_d        = w_q;
        w_d.done   = 1'b0;
        guard_init = 1'b0;
        guard_step = 1'b0;
        cost_init  = 1'b0;
        cost_add   = 1'b0;
        unique case (w_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    w_d.loop_abort = 1'b0;
                    w_d.rd_addr    = word_addr(start_addr_i);
                    guard_init     = 1'b1;
                    cost_init      = 1'b1;
                    if (start_addr_i[END_BIT]) begin
                        w_d.done = 1'b1;
                    end else begin
                        w_d.st = ST_HDR_REQ;
                    end
                end
            end
            ST_HDR_REQ: begin
                if (mem_req_ready_i) w_d.st = ST_HDR_WAIT;
            end
            ST_HDR_WAIT: begin
                if (mem_rsp_valid_i) begin
                    w_d.len       = hdr_len;
                    w_d.next_addr = hdr_next;
                    w_d.idx       = '0;
                    w_d.rd_addr   = w_q.rd_addr + MEM_AW'(WORD_BYTES);
                    cost_add      = 1'b1;
                    w_d.st        = (hdr_len == '0) ? ST_LINK : ST_PAY_REQ;
                end
            end
            ST_PAY_REQ: begin
                if (mem_req_ready_i) w_d.st = ST_PAY_WAIT;
            end
            ST_PAY_WAIT: begin
                if (mem_rsp_valid_i) begin
                    w_d.word = mem_rsp_data_i;
                    w_d.st   = ST_PAY_SEND;
                end
            end
            ST_PAY_SEND: begin
                if (cmd_ready_i) begin
                    if (w_q.idx == w_q.len - 1'b1) begin
                        w_d.st = ST_LINK;
                    end else begin
                        w_d.idx     = w_q.idx + 1'b1;
                        w_d.rd_addr = w_q.rd_addr + MEM_AW'(WORD_BYTES);
                        w_d.st      = ST_PAY_REQ;
                    end
                end
            end
            ST_LINK: begin
                guard_step = 1'b1;
                if (loop_hit) begin
                    w_d.loop_abort = 1'b1;
                    w_d.done       = 1'b1;
                    w_d.st         = ST_IDLE;
                end else if (w_q.next_addr[END_BIT]) begin
                    w_d.done = 1'b1;
                    w_d.st   = ST_IDLE;
                end else begin
                    w_d.rd_addr = word_addr(w_q.next_addr);
                    w_d.st      = ST_HDR_REQ;
                end
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= ST_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    lldma_loop_guard #(
        .ADDR_W        (ADDR_W),
        .CNT_W         (CNT_W),
        .FIRST_INTERVAL(FIRST_INTERVAL)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (guard_init),
        .init_addr_i(start_addr_i),
        .step_i     (guard_step),
        .next_addr_i(w_q.next_addr),
        .hit_o      (loop_hit)
    );

    lldma_cost_acc #(
        .COST_W    (COST_W),
        .LEN_W     (LEN_W),
        .NODE_COST (NODE_COST),
        .BLOCK_COST(BLOCK_COST)
    ) u_cost (
        .clk   (clk),
        .rst_n (rst_n),
        .init_i(cost_init),
        .add_i (cost_add),
        .len_i (hdr_len),
        .cost_o(cost_o)
    );

    assign mem_req_valid_o = (w_q.st == ST_HDR_REQ) || (w_q.st == ST_PAY_REQ);
    assign mem_req_addr_o  = w_q.rd_addr;
    assign cmd_valid_o     = (w_q.st == ST_PAY_SEND);
    assign cmd_data_o      = w_q.word;
    assign busy_o          = (w_q.st != ST_IDLE);
    assign done_o          = w_q.done;
    assign loop_abort_o    = w_q.loop_abort;

endmodule

// File: rtl/lldma_walker_chk.sv
// Protocol checks for the walker, attached through bind.
module lldma_walker_chk #(
    parameter int MEM_AW   = 21,
    parameter int DATA_W   = 32,
    parameter int WORD_LSB = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              loop_abort_o,
    input logic              mem_req_valid_o,
    input logic [MEM_AW-1:0] mem_req_addr_o,
    input logic              cmd_valid_o,
    input logic              cmd_ready_i,
    input logic [DATA_W-1:0] cmd_data_o
);

    assert_req_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (mem_req_addr_o[WORD_LSB-1:0] == '0));

    assert_no_req_while_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !mem_req_valid_o);

    assert_word_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_data_o)));

    assert_abort_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_abort_o) |-> done_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_flag_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(loop_abort_o));

endmodule

bind lldma_walker lldma_walker_chk #(
    .MEM_AW  (MEM_AW),
    .DATA_W  (DATA_W),
    .WORD_LSB(WORD_LSB)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .loop_abort_o   (loop_abort_o),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_addr_o (mem_req_addr_o),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_ready_i    (cmd_ready_i),
    .cmd_data_o     (cmd_data_o)
);

// File: tb/lldma_walker_tb.sv
`timescale 1ns/1ps
module lldma_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic        mem_req_valid, mem_req_ready;
    logic [20:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        cmd_valid, cmd_ready;
    logic [31:0] cmd_data;
    logic        busy, done, loop_abort;
    logic [31:0] cost;

    always #2 clk = ~clk;   // 250 MHz

    lldma_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
        .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data), .cmd_valid_o(cmd_valid),
        .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data), .busy_o(busy),
        .done_o(done), .loop_abort_o(loop_abort), .cost_o(cost)
    );

    typedef struct packed {
        logic [15:0] base;
        logic [7:0]  nodes;
        logic [7:0]  loop_to;   // 8'hFF: chain ends with the marker
        logic [3:0]  seed;
        logic [3:0]  lat;
        logic [1:0]  rmode;
        logic        loops;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 8'd5,  8'hFF, 4'd1, 4'd1, 2'd0, 1'b0},
        '{16'h0400, 8'd3,  8'hFF, 4'd0, 4'd3, 2'd1, 1'b0},
        '{16'h1000, 8'd1,  8'd0,  4'd2, 4'd1, 2'd0, 1'b1},
        '{16'h2000, 8'd40, 8'd0,  4'd3, 4'd2, 2'd2, 1'b1},
        '{16'h0800, 8'd10, 8'd5,  4'd4, 4'd1, 2'd0, 1'b1},
        '{16'h0000, 8'd34, 8'hFF, 4'd1, 4'd1, 2'd1, 1'b0}
    };

    logic [31:0] mem [0:4095];
    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];
    int          checks = 0, fails = 0, cyc = 0;
    int          lat = 1, rmode = 0, pend = 0, nreq = 0, ndone = 0;
    logic [20:0] pend_addr = '0, first_req = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] exp_cost;
    logic        exp_loop;

    assign mem_req_ready = 1'b1;
    initial cmd_ready = 1'b1;

    function automatic int midx(input logic [23:0] a);
        return int'((a & 24'h1FFFFF) >> 2) & 4095;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // consumer, memory model, monitors and watchdog: all away from the active edge
    always @(negedge clk) begin
        cyc++;
        case (rmode)
            0: cmd_ready = 1'b1;
            1: cmd_ready = ~cmd_ready;
            default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cmd_ready = lfsr[0];
            end
        endcase
        if (cmd_valid && cmd_ready) got_q.push_back(cmd_data);
        mem_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[midx({3'b000, pend_addr})];
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            if (nreq == 0) first_req = mem_req_addr;
            nreq++;
            pend = lat;
            pend_addr = mem_req_addr;
        end
        if (done) ndone++;
        if (cyc > 190000) begin
            check(1'b0, "WATCHDOG", "cycles", cyc, 190000);
            finish_run();
        end
    end

    task automatic build_list(input int base, input int n, input int loop_to, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [23:0] a, nxt;
            logic [7:0]  len;
            a   = 24'(base + i * 64);
            len = 8'((i + seed) % 5);
            if (i != n - 1)          nxt = 24'(base + (i + 1) * 64);
            else if (loop_to == 255) nxt = 24'h800000;
            else                     nxt = 24'(base + loop_to * 64);
            mem[midx(a)] = {len, nxt};
            for (int k = 0; k < int'(len); k++)
                mem[midx(a + 24'(4 * (k + 1)))] = 32'hC0DE0000 ^ {4'(seed), 8'(k), 20'(a)};
        end
    endtask

    // Reference walk of the memory image, following the requirement text.
    task automatic ref_walk(input logic [23:0] s);
        logic [23:0] cur, ck, nxt;
        logic [7:0]  len;
        logic [31:0] h;
        int          iv, cnt;
        exp_q.delete();
        exp_cost = 0; exp_loop = 0;
        cur = s; ck = s; iv = 32; cnt = 0;
        if (!cur[23]) begin
            for (int step = 0; step < 5000; step++) begin
                h = mem[midx(cur)];
                len = h[31:24];
                nxt = h[23:0];
                for (int k = 0; k < int'(len); k++)
                    exp_q.push_back(mem[midx(cur + 24'(4 * (k + 1)))]);
                exp_cost += 10;
                if (len != 0) exp_cost += 5 + 32'(len);
                if (nxt == ck) begin exp_loop = 1; break; end
                if (nxt[23]) break;
                if (cnt == iv) begin ck = nxt; iv = iv * 2; end
                cnt++;
                cur = nxt;
            end
        end
    endtask

    task automatic run_walk(input logic [23:0] s, input bit glitch, input string tag);
        int t;
        logic [31:0] c_at_done;
        logic        l_at_done;
        got_q.delete();
        nreq = 0; ndone = 0;
        ref_walk(s);
        @(negedge clk);
        start = 1'b1; start_addr = s;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 50000) begin
            @(negedge clk);
            t++;
            if (glitch && t == 6) begin
                check(busy, "R9", {tag, " busy at second start"}, busy, 1);
                start = 1'b1; start_addr = 24'h800000;
            end
            if (glitch && t == 7) start = 1'b0;
        end
        check(done, "R8", {tag, " done seen"}, done, 1);
        check(got_q.size() == exp_q.size(), "R3", {tag, " word count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
            if (got_q[i] !== exp_q[i]) begin
                check(1'b0, "R4", {tag, " word order/value"}, got_q[i], exp_q[i]);
                break;
            end
        end
        check(cost == exp_cost, "R6", {tag, " cost"}, cost, exp_cost);
        check(loop_abort == exp_loop, "R7", {tag, " loop flag"}, loop_abort, exp_loop);
        c_at_done = cost; l_at_done = loop_abort;
        @(negedge clk);
        check(!done && !busy, "R8", {tag, " done one cycle"}, done, 0);
        check(cost == c_at_done && loop_abort == l_at_done, "R8", {tag, " results held"},
              {cost, 31'b0, loop_abort}, {c_at_done, 31'b0, l_at_done});
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h00800000;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !loop_abort && !mem_req_valid && !cmd_valid && cost == 0,
              "R1", "reset outputs", {busy, done, loop_abort, mem_req_valid, cmd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table-driven walks
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("vec%0d", v);
            build_list(int'(VECS[v].base), int'(VECS[v].nodes),
                       int'(VECS[v].loop_to), int'(VECS[v].seed));
            lat = int'(VECS[v].lat);
            rmode = int'(VECS[v].rmode);
            run_walk({8'h00, VECS[v].base}, 1'b0, tag);
            check(exp_loop == VECS[v].loops, "R7", {tag, " table loop expectation"},
                  loop_abort, VECS[v].loops);
        end

        // R5: start on the end marker, fixed latency, no memory traffic
        rmode = 0; lat = 1; nreq = 0;
        @(negedge clk);
        start = 1'b1; start_addr = 24'h812345;
        @(negedge clk);
        start = 1'b0;
        check(done, "R5", "done in cycle after start edge", done, 1);
        check(cost == 0 && !loop_abort, "R5", "marker start cost", cost, 0);
        @(negedge clk);
        check(!done, "R8", "marker start done pulse width", done, 0);
        check(nreq == 0, "R5", "no memory request on marker start", nreq, 0);

        // R2: upper address bits do not reach memory
        build_list(32'h3000, 1, 255, 2);
        mem[midx(24'h003000)] = {8'd2, 24'h A03000};
        run_walk(24'h603000, 1'b0, "alias");
        check(first_req == 21'h003000, "R2", "header request address", first_req, 21'h003000);
        check(nreq == 3, "R2", "header plus payload requests", nreq, 3);

        // R9: start during a walk is ignored
        build_list(32'h0000, 5, 255, 1);
        lat = 1; rmode = 0;
        run_walk(24'h000000, 1'b1, "restart");
        repeat (4) @(negedge clk);
        check(ndone == 1, "R9", "single done for one walk", ndone, 1);

        finish_run();
    end

endmodule